// File: doc/BRIEF.md
# Pointer Address Generator with Modifier Arithmetic

The block forms operand addresses for a DSP-style datapath from eight register sets. Each set holds a pointer register, an offset register and a modifier register. On a cycle with an access request, the caller names a set and an addressing mode. The block then places the effective address on its output in the same cycle, without a register stage. For the update modes, it writes a new pointer value back into the same set at the next clock edge.

The modifier register of the set chooses how the pointer is updated. It can select plain linear arithmetic, arithmetic that wraps inside a circular buffer, or reverse-carry arithmetic for bit-reversed (FFT-style) ordering. The offset register is read as a two's-complement number, so a single adder covers both forward and backward strides.

A host port loads any register and reads any register back. Host reads are combinational.

Top module: `agu_core`

## Requirements
- R1: Mode code 0 (no update) places the pointer of the selected set on `ea_out`, and no register changes. Codes 6 and 7 behave the same as code 0.
- R2: Mode code 1 places the current pointer on `ea_out` and stores pointer+1 (formed by the set's modifier arithmetic) into that pointer at the next edge.
- R3: Mode code 2 places the current pointer on `ea_out` and stores pointer-1 (formed by the modifier arithmetic) at the next edge.
- R4: Mode code 3 places the current pointer on `ea_out` and stores pointer+offset at the next edge. The offset register keeps its value.
- R5: Mode code 4 places the current pointer on `ea_out` and stores pointer-offset at the next edge. The offset register keeps its value.
- R6: Mode code 5 (indexed) places pointer+offset, modulo 2^AW, on `ea_out`. No register changes.
- R7: When the modifier is all ones, the update is linear and wraps at 2^AW.
- R8: When the modifier M lies strictly between zero and all ones, the update works in a circular buffer of M+1 words. The buffer base is the pointer with its low k bits cleared, where 2^k is the smallest power of two at or above M+1. The position of the pointer inside the buffer is shifted by the signed step. If the result is above M, M+1 is subtracted once. If it is below 0, M+1 is added once.
- R9: When the modifier is zero, the update is a reverse-carry addition of the signed step, with carries running from the MSB toward the LSB.
- R10: `ea_out` is combinational from the current registers. A write-back is visible to an access to the same set in the very next cycle.
- R11: The host port works as follows:
  - `host_we` writes `host_wdata` at the next edge into the register picked by `host_kind` (0 pointer, 1 offset, 2 modifier, 3 nothing) in set `host_idx`.
  - `host_rdata` combinationally returns the register picked by `host_kind` and `host_idx`, and returns 0 for kind 3.
  - A host write to a pointer takes priority over a same-cycle write-back to that pointer.
- R12: After reset, every pointer and offset is 0 and every modifier is all ones (linear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_set | input | IW | Register set selected by the access |
| acc_mode | input | 3 | Addressing mode code |
| ea_out | output | AW | Effective address |
| host_we | input | 1 | Host register write enable |
| host_kind | input | 2 | Host register kind: 0 pointer, 1 offset, 2 modifier |
| host_idx | input | IW | Host register set index |
| host_wdata | input | AW | Host write data |
| host_rdata | output | AW | Host read data |

## Verification
The bench builds the block with its default values: AW=32 and eight sets. With a 32-bit pointer, linear wrap at 2^32 can be reached by loading a pointer near all ones. Modulo buffers both of power-of-two size and of other sizes can be placed at arbitrary bases. Offsets of either sign can step past either end of a buffer. A random phase mixes all eight mode codes with host writes of zero, all-ones and small modifier values, including host writes that collide with a write-back.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    MD_NONE = 3'd0,
    MD_INC1 = 3'd1,
    MD_DEC1 = 3'd2,
    MD_INCN = 3'd3,
    MD_DECN = 3'd4,
    MD_IDX  = 3'd5
  } agu_mode_e;

  typedef enum logic [1:0] {
    HK_PTR = 2'd0,
    HK_OFS = 2'd1,
    HK_MOD = 2'd2,
    HK_NUL = 2'd3
  } host_kind_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW    = 32,
  parameter int NSETS = 8,
  localparam int IW   = $clog2(NSETS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wb_en,
  input  logic [IW-1:0]             wb_idx,
  input  logic [AW-1:0]             wb_data,
  input  logic                      host_we,
  input  logic [1:0]                host_kind,
  input  logic [IW-1:0]             host_idx,
  input  logic [AW-1:0]             host_wdata,
  output logic [NSETS-1:0][AW-1:0]  r_all,
  output logic [NSETS-1:0][AW-1:0]  n_all,
  output logic [NSETS-1:0][AW-1:0]  m_all
);
  import agu_pkg::*;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic host_r, host_n, host_m;
    assign host_r = host_we && (host_idx == IW'(g)) && (host_kind == HK_PTR);
    assign host_n = host_we && (host_idx == IW'(g)) && (host_kind == HK_OFS);
    assign host_m = host_we && (host_idx == IW'(g)) && (host_kind == HK_MOD);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_all[g] <= '0;
        n_all[g] <= '0;
        m_all[g] <= '1;
      end else begin
        if (host_r)                            r_all[g] <= host_wdata;
        else if (wb_en && wb_idx == IW'(g))    r_all[g] <= wb_data;
        if (host_n) n_all[g] <= host_wdata;
        if (host_m) m_all[g] <= host_wdata;
      end
    end
  end
endmodule

// File: rtl/agu_modifier.sv
module agu_modifier #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] modv,
  output logic [AW-1:0] nxt,
  output logic          is_lin,
  output logic          is_rev
);
  function automatic logic [AW-1:0] bit_rev(input logic [AW-1:0] v);
    logic [AW-1:0] o;
    for (int i = 0; i < AW; i++) o[i] = v[AW-1-i];
    return o;
  endfunction

  function automatic logic [AW-1:0] fill_right(input logic [AW-1:0] v);
    logic [AW-1:0] o;
    o = v;
    for (int sh = 1; sh < AW; sh = sh * 2) o = o | (o >> sh);
    return o;
  endfunction

  function automatic logic [AW-1:0] mod_update(input logic [AW-1:0] p,
                                               input logic [AW-1:0] s,
                                               input logic [AW-1:0] m);
    logic [AW-1:0]        mask, base;
    logic signed [AW+1:0] t, sz;
    mask = fill_right(m);
    base = p & ~mask;
    sz   = $signed({2'b00, m}) + 1;
    t    = $signed({2'b00, p & mask}) + $signed({s[AW-1], s[AW-1], s});
    if (t > $signed({2'b00, m}))  t = t - sz;
    else if (t < 0)               t = t + sz;
    return base + t[AW-1:0];
  endfunction

  assign is_lin = &modv;
  assign is_rev = ~|modv;

  always_comb begin
    if (is_lin)      nxt = ptr + step;
    else if (is_rev) nxt = bit_rev(bit_rev(ptr) + bit_rev(step));
    else             nxt = mod_update(ptr, step, modv);
  end
endmodule

// File: rtl/agu_core.sv
module agu_core #(
  parameter int AW    = 32,
  parameter int NSETS = 8,
  localparam int IW   = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_set,
  input  logic [2:0]    acc_mode,
  output logic [AW-1:0] ea_out,
  input  logic          host_we,
  input  logic [1:0]    host_kind,
  input  logic [IW-1:0] host_idx,
  input  logic [AW-1:0] host_wdata,
  output logic [AW-1:0] host_rdata
);
  import agu_pkg::*;

  logic [NSETS-1:0][AW-1:0] r_all, n_all, m_all;
  logic [AW-1:0] cur_r, cur_n, cur_m, step, nxt_r;
  logic          upd_mode, wb_en, arith_lin, arith_rev;

  assign cur_r = r_all[acc_set];
  assign cur_n = n_all[acc_set];
  assign cur_m = m_all[acc_set];

  always_comb begin
    upd_mode = 1'b1;
    case (acc_mode)
      MD_INC1: step = AW'(1);
      MD_DEC1: step = '1;
      MD_INCN: step = cur_n;
      MD_DECN: step = -cur_n;
      default: begin
        step     = '0;
        upd_mode = 1'b0;
      end
    endcase
  end

  assign ea_out = (acc_mode == MD_IDX) ? cur_r + cur_n : cur_r;
  assign wb_en  = acc_valid && upd_mode;

  agu_modifier #(.AW(AW)) u_mod (
    .ptr(cur_r), .step(step), .modv(cur_m),
    .nxt(nxt_r), .is_lin(arith_lin), .is_rev(arith_rev)
  );

  agu_regfile #(.AW(AW), .NSETS(NSETS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wb_en(wb_en), .wb_idx(acc_set), .wb_data(nxt_r),
    .host_we(host_we), .host_kind(host_kind), .host_idx(host_idx),
    .host_wdata(host_wdata),
    .r_all(r_all), .n_all(n_all), .m_all(m_all)
  );

  always_comb begin
    case (host_kind)
      HK_PTR:  host_rdata = r_all[host_idx];
      HK_OFS:  host_rdata = n_all[host_idx];
      HK_MOD:  host_rdata = m_all[host_idx];
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/agu_core_checker.sv
module agu_core_checker #(
  parameter int AW    = 32,
  parameter int NSETS = 8,
  localparam int IW   = $clog2(NSETS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     acc_valid,
  input logic [IW-1:0]            acc_set,
  input logic [2:0]               acc_mode,
  input logic                     host_we,
  input logic [AW-1:0]            ea_out,
  input logic                     wb_en,
  input logic [NSETS-1:0][AW-1:0] r_all,
  input logic [NSETS-1:0][AW-1:0] n_all,
  input logic [NSETS-1:0][AW-1:0] m_all
);
  // R1: no-update access with no host write leaves every register unchanged
  a_r1_no_update_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode == 3'd0 && !host_we) |=> ($stable(r_all) && $stable(n_all) && $stable(m_all)));

  // R2: non-indexed modes present the current pointer
  a_r2_ea_is_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode != 3'd5) |-> (ea_out == r_all[acc_set]));

  // R6: indexed mode presents pointer plus offset and schedules no write-back
  a_r6_indexed_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode == 3'd5) |-> (ea_out == r_all[acc_set] + n_all[acc_set] && !wb_en));

  // R4: offsets and modifiers change only through the host port
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> ($stable(n_all) && $stable(m_all)));

  // R7: linear postincrement lands on pointer+1 in the next cycle
  a_r7_linear_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode == 3'd1 && (&m_all[acc_set]) && !host_we)
      |=> (r_all[$past(acc_set)] == $past(r_all[acc_set]) + 1'b1));
endmodule

bind agu_core agu_core_checker #(.AW(AW), .NSETS(NSETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
  .acc_mode(acc_mode), .host_we(host_we), .ea_out(ea_out), .wb_en(wb_en),
  .r_all(r_all), .n_all(n_all), .m_all(m_all)
);

// File: tb/agu_core_bench.sv
`timescale 1ns/1ps
module agu_core_bench;
  localparam int AW = 32;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [2:0]    acc_set = '0;
  logic [2:0]    acc_mode = '0;
  logic [AW-1:0] ea_out;
  logic          host_we = 1'b0;
  logic [1:0]    host_kind = '0;
  logic [2:0]    host_idx = '0;
  logic [AW-1:0] host_wdata = '0;
  logic [AW-1:0] host_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] mr [NS];
  logic [31:0] mn [NS];
  logic [31:0] mm [NS];

  always #2.5 clk = ~clk;

  agu_core #(.AW(AW), .NSETS(NS)) u_agu_core (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_mode(acc_mode), .ea_out(ea_out), .host_we(host_we),
    .host_kind(host_kind), .host_idx(host_idx), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  function automatic logic [31:0] rc_add(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s;
    logic c;
    c = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
    end
    return s;
  endfunction

  function automatic logic [31:0] ref_update(input logic [31:0] p, input logic [31:0] s,
                                              input logic [31:0] m);
    longint sz, pw, base, off, t;
    if (m == 32'hFFFF_FFFF) return p + s;
    if (m == 32'd0) return rc_add(p, s);
    sz = longint'(m) + 1;
    pw = 1;
    while (pw < sz) pw = pw * 2;
    base = longint'(p) - (longint'(p) % pw);
    off  = longint'(p) % pw;
    t    = off + longint'($signed(s));
    if (t > longint'(m)) t = t - sz;
    else if (t < 0) t = t + sz;
    return 32'(base + t);
  endfunction

  function automatic string arith_tag(input logic [31:0] m);
    if (m == 32'hFFFF_FFFF) return "R7";
    if (m == 32'd0) return "R9";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock of stimulus; checks at mid-cycle, model advances at the edge
  task automatic cyc(input bit v, input int set, input int mode, input bit hwe,
                     input int kind, input int idx, input logic [31:0] data);
    logic [31:0] exp_ea, stp;
    string mtag;
    bit upd;
    @(negedge clk);
    acc_valid = v; acc_set = 3'(set); acc_mode = 3'(mode);
    host_we = hwe; host_kind = 2'(kind); host_idx = 3'(idx); host_wdata = data;
    #1;
    upd = 1'b1;
    case (mode)
      1: begin stp = 32'd1;         mtag = "R2"; end
      2: begin stp = 32'hFFFF_FFFF; mtag = "R3"; end
      3: begin stp = mn[set];       mtag = "R4"; end
      4: begin stp = 32'd0 - mn[set]; mtag = "R5"; end
      5: begin stp = 0; upd = 1'b0; mtag = "R6"; end
      default: begin stp = 0; upd = 1'b0; mtag = "R1"; end
    endcase
    exp_ea = (mode == 5) ? mr[set] + mn[set] : mr[set];
    if (v) check({mtag, " R10 ea"}, ea_out, exp_ea);
    case (kind)
      0: check("R11 rdata ptr", host_rdata, mr[idx]);
      1: check("R11 rdata ofs", host_rdata, mn[idx]);
      2: check("R11 rdata mod", host_rdata, mm[idx]);
      default: check("R11 rdata none", host_rdata, 32'd0);
    endcase
    @(posedge clk);
    if (v && upd) mr[set] = ref_update(mr[set], stp, mm[set]);
    if (hwe) begin
      if (kind == 0) mr[idx] = data;
      else if (kind == 1) mn[idx] = data;
      else if (kind == 2) mm[idx] = data;
    end
  endtask

  task automatic hw(input int kind, input int idx, input logic [31:0] data);
    cyc(0, 0, 0, 1, kind, idx, data);
  endtask

  task automatic verify_set(input int s);
    cyc(0, 0, 0, 0, 0, s, 0);
    cyc(0, 0, 0, 0, 1, s, 0);
    cyc(0, 0, 0, 0, 2, s, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      mr[i] = 0; mn[i] = 0; mm[i] = 32'hFFFF_FFFF;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12: reset values read back through the host port
    for (int i = 0; i < NS; i++) begin
      @(negedge clk); host_idx = 3'(i);
      host_kind = 2'd0; #0.5 check("R12 ptr reset", host_rdata, 32'd0);
      host_kind = 2'd1; #0.5 check("R12 ofs reset", host_rdata, 32'd0);
      host_kind = 2'd2; #0.5 check("R12 mod reset", host_rdata, 32'hFFFF_FFFF);
    end
    // R7: linear wrap across 2^32
    hw(0, 0, 32'hFFFF_FFFE); hw(1, 0, 32'd3);
    cyc(1, 0, 1, 0, 0, 0, 0); cyc(1, 0, 1, 0, 0, 0, 0); cyc(1, 0, 2, 0, 0, 0, 0);
    cyc(1, 0, 3, 0, 0, 0, 0); cyc(1, 0, 4, 0, 0, 0, 0); cyc(1, 0, 4, 0, 0, 0, 0);
    cyc(1, 0, 5, 0, 0, 0, 0); verify_set(0);
    // R8: modulo 10 buffer at 0x100, stepping past both ends
    hw(2, 1, 32'd9); hw(0, 1, 32'h105); hw(1, 1, 32'd4);
    for (int k = 0; k < 6; k++) cyc(1, 1, 3, 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) cyc(1, 1, 4, 0, 0, 0, 0);
    cyc(1, 1, 2, 0, 0, 0, 0); hw(0, 1, 32'h100); cyc(1, 1, 2, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0, 0); verify_set(1);
    // R8: modulo 5 buffer with negative offset
    hw(2, 3, 32'd4); hw(0, 3, 32'h2A); hw(1, 3, 32'hFFFF_FFFE);
    for (int k = 0; k < 5; k++) cyc(1, 3, 3, 0, 0, 0, 0);
    // R9: reverse-carry with offset 8 gives bit-reversed ordering
    hw(2, 2, 32'd0); hw(1, 2, 32'd8);
    for (int k = 0; k < 9; k++) cyc(1, 2, 3, 0, 0, 0, 0);
    cyc(1, 2, 1, 0, 0, 0, 0); cyc(1, 2, 2, 0, 0, 0, 0);
    // R1: codes 0, 6, 7 change nothing; R6: indexed leaves registers alone
    cyc(1, 1, 0, 0, 0, 0, 0); cyc(1, 1, 6, 0, 0, 0, 0); cyc(1, 1, 7, 0, 0, 0, 0);
    cyc(1, 1, 5, 0, 0, 0, 0); verify_set(1);
    // R11: host write wins over same-cycle write-back; kind 3 writes nothing
    cyc(1, 4, 1, 1, 0, 4, 32'hABCD_0000); verify_set(4);
    cyc(1, 4, 3, 1, 3, 4, 32'h1234_5678); verify_set(4);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int r, dsel;
      logic [31:0] d;
      r = $urandom_range(0, 9);
      dsel = $urandom_range(0, 4);
      d = (dsel == 0) ? 32'd0 : (dsel == 1) ? 32'hFFFF_FFFF :
          (dsel == 2) ? 32'($urandom_range(1, 40)) :
          (dsel == 3) ? 32'd0 - 32'($urandom_range(1, 20)) : $urandom;
      cyc($urandom_range(0, 4) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
          r < 3, $urandom_range(0, 3), $urandom_range(0, 7), d);
    end
    for (int i = 0; i < NS; i++) verify_set(i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule